// File: doc/BRIEF.md
# Auto-Incrementing Colour Palette Port

This block gives a host access to a colour lookup table of 256 entries. Each entry holds 24 bits: red, green and blue, one byte each. The host sees one 32-bit register with four byte lanes. Lane 0 is the write index, lane 1 is the colour data, lane 2 is the pixel mask and lane 3 is the read index. To load an entry, the host sets an index once and then makes three data accesses in a row, red first, then green, then blue. After each complete triple the index moves on to the next entry by itself.

One component counter serves both directions. Data writes are gathered in three staging bytes and are committed to the table together. A data read copies the whole entry into the same staging bytes when the counter is 0. A separate registered port lets the display pipeline look up one entry per cycle by pixel value.

Top module: `palette_dac_port`

## Requirements
- R1: After reset, both indices are 0, the mask is 0xFF and the component counter is 0. A read returns 0x00FF0000 with lane 1 disabled.
- R2: A write that enables lane 0 or lane 3 loads that index from the lane and clears the component counter. A data byte in the same access is ignored.
- R3: A data write (lane 1) stores the lane byte ANDed with the mask into the staging slot selected by the counter, then advances the counter. The mask used is the value held before the access. A lane 2 write loads a new mask, and nothing else changes it.
- R4: The third data write commits {slot0, slot1, slot2} to the entry at the write index, with red in bits [23:16]. The write index then increments, wrapping from 255 to 0, and the counter returns to 0.
- R5: A data read (lane 1) with the counter at 0 fetches the entry at the read index into the staging slots. Every data read returns the slot selected by the counter in lane 1 of the read data, together with host_rvalid, one cycle after the request. It then advances the counter.
- R6: The third data read increments the read index, wrapping from 255 to 0, and returns the counter to 0.
- R7: Every read returns the write index in lane 0, the mask in lane 2 and the read index in lane 3, sampled before the access. When lane 1 is not enabled, lane 1 reads 0 and the counter does not move.
- R8: The pixel port returns the entry at pix_idx on pix_rgb one cycle later.
- R9: A read request made in the same cycle as a write is ignored: no host_rvalid follows.
- R10: Reads and writes share the counter and the staging slots. A data read that follows a partial write triple returns the slot at the current count, without fetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_be | input | 4 | Byte-lane enables |
| host_wdata | input | 32 | Write data, four lanes |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| pix_idx | input | 8 | Display lookup index |
| pix_rgb | output | 24 | Display lookup entry, registered |

## Verification
The bench builds the block with its default parameters: an 8-bit index, 8-bit components and 256 entries. This puts the 255-to-0 wrap of both indices within reach with a single index write. A reference model in the bench holds the index, mask, counter and staging state, and a scoreboard queue compares every read the model predicts. This covers mixed read and write triples that share the counter, masked loads, and lookups on the pixel port of entries the host has committed.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // byte-lane numbers of the host register; the lane order is the register layout
  localparam int LANE_WIDX = 0;
  localparam int LANE_DATA = 1;
  localparam int LANE_MASK = 2;
  localparam int LANE_RIDX = 3;
  localparam int N_LANES   = 4;
  localparam int N_COMP    = 3;   // red, green, blue
  localparam int CNT_W     = 2;

  // advance the component counter, folding back to 0 after the last slot
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(N_COMP - 1)) ? '0 : c + 1'b1;
  endfunction
endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W = 8,
  parameter int EW    = 24
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [EW-1:0]    wdata,
  input  logic [IDX_W-1:0] haddr,
  output logic [EW-1:0]    hdata,
  input  logic [IDX_W-1:0] paddr,
  output logic [EW-1:0]    pdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    pdata <= mem[paddr];
  end

  assign hdata = mem[haddr];
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [N_LANES-1:0] be,
  input  logic [N_LANES*CW-1:0] wdata,
  output logic [N_LANES*CW-1:0] rdata,
  output logic               rvalid,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               ram_we,
  output logic [N_COMP*CW-1:0] ram_wdata,
  input  logic [N_COMP*CW-1:0] fetch_entry
);
  localparam int EW = N_COMP * CW;

  logic [CW-1:0]    mask;
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    stage [N_COMP];

  // named events, shared with the assertions
  logic idx_wr, data_wr, rd_acc, data_rd, last_comp;
  logic commit_evt, rd_done_evt, fetch_evt;
  logic [CW-1:0] wbyte, rbyte;

  function automatic logic [CW-1:0] comp_of(input logic [EW-1:0] e, input int k);
    return e[EW-1-k*CW -: CW];
  endfunction

  function automatic logic [CW-1:0] lane_ext(input logic [IDX_W-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    r[IDX_W-1:0] = v;
    return r;
  endfunction

  assign idx_wr      = wr && (be[LANE_WIDX] || be[LANE_RIDX]);
  assign data_wr     = wr && be[LANE_DATA] && !idx_wr;
  assign rd_acc      = rd && !wr;
  assign data_rd     = rd_acc && be[LANE_DATA];
  assign last_comp   = (cnt == CNT_W'(N_COMP - 1));
  assign commit_evt  = data_wr && last_comp;
  assign rd_done_evt = data_rd && last_comp;
  assign fetch_evt   = data_rd && (cnt == '0);
  assign wbyte       = wdata[LANE_DATA*CW +: CW] & mask;
  assign rbyte       = (cnt == '0) ? comp_of(fetch_entry, 0) : stage[cnt];

  // commit image: staged slots, with the incoming byte in the current slot
  for (genvar k = 0; k < N_COMP; k++) begin : g_img
    assign ram_wdata[EW-1-k*CW -: CW] = (cnt == CNT_W'(k)) ? wbyte : stage[k];
  end
  assign ram_we = commit_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      mask   <= '1;
      cnt    <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
      for (int k = 0; k < N_COMP; k++) stage[k] <= '0;
    end else begin
      rvalid <= rd_acc;
      if (rd_acc)
        rdata <= {lane_ext(rd_idx), mask, (be[LANE_DATA] ? rbyte : CW'(0)), lane_ext(wr_idx)};

      if (wr && be[LANE_MASK]) mask <= wdata[LANE_MASK*CW +: CW];

      if (wr && be[LANE_WIDX])   wr_idx <= wdata[LANE_WIDX*CW +: IDX_W];
      else if (commit_evt)       wr_idx <= wr_idx + 1'b1;

      if (wr && be[LANE_RIDX])   rd_idx <= wdata[LANE_RIDX*CW +: IDX_W];
      else if (rd_done_evt)      rd_idx <= rd_idx + 1'b1;

      if (idx_wr)                 cnt <= '0;
      else if (data_wr || data_rd) cnt <= cnt_step(cnt);

      if (data_wr) stage[cnt] <= wbyte;
      else if (fetch_evt)
        for (int k = 0; k < N_COMP; k++) stage[k] <= comp_of(fetch_entry, k);
    end
  end

  AST_IDX_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (cnt == '0)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && be[LANE_MASK]) |=> $stable(mask)); // R3
  AST_WIDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1))); // R4
  AST_RIDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_evt |=> (rd_idx == IDX_W'($past(rd_idx) + 1'b1))); // R6
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rvalid); // R5
  AST_RD_WR_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |=> !rvalid); // R9
endmodule

// File: rtl/palette_dac_port.sv
module palette_dac_port
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [3:0]           host_be,
  input  logic [4*CW-1:0]      host_wdata,
  output logic [4*CW-1:0]      host_rdata,
  output logic                 host_rvalid,
  input  logic [IDX_W-1:0]     pix_idx,
  output logic [3*CW-1:0]      pix_rgb
);
  localparam int EW = N_COMP * CW;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             ram_we;
  logic [EW-1:0]    ram_wdata, fetch_entry;

  pal_seq #(.IDX_W(IDX_W), .CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (host_wr),
    .rd          (host_rd),
    .be          (host_be),
    .wdata       (host_wdata),
    .rdata       (host_rdata),
    .rvalid      (host_rvalid),
    .wr_idx      (wr_idx),
    .rd_idx      (rd_idx),
    .ram_we      (ram_we),
    .ram_wdata   (ram_wdata),
    .fetch_entry (fetch_entry)
  );

  pal_ram #(.IDX_W(IDX_W), .EW(EW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (wr_idx),
    .wdata (ram_wdata),
    .haddr (rd_idx),
    .hdata (fetch_entry),
    .paddr (pix_idx),
    .pdata (pix_rgb)
  );

  AST_COMMIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (host_wr && host_be[LANE_DATA])); // R4
endmodule

// File: tb/test_palette_dac_port.sv
module test_palette_dac_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [3:0]  host_be = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [7:0]  pix_idx = 0;
  logic [23:0] pix_rgb;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference model state
  logic [23:0] ref_mem [256];
  logic [7:0]  m_wi = 0, m_ri = 0, m_mask = 8'hFF;
  int          m_cnt = 0;
  logic [7:0]  m_st [3] = '{8'h0, 8'h0, 8'h0};

  always #2 clk = ~clk;   // 250 MHz

  palette_dac_port i_palette_dac_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .pix_idx(pix_idx), .pix_rgb(pix_rgb));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop one expectation per returned read
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected rvalid", host_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  task automatic hwrite(input logic [3:0] be, input logic [31:0] d);
    logic [7:0] b;
    @(negedge clk);
    host_wr = 1; host_be = be; host_wdata = d;
    // model per R2/R3/R4
    if (be[0]) m_wi = d[7:0];
    if (be[3]) m_ri = d[31:24];
    if (be[0] || be[3]) m_cnt = 0;
    else if (be[1]) begin
      b = d[15:8] & m_mask;
      m_st[m_cnt] = b;
      if (m_cnt == 2) begin
        ref_mem[m_wi] = {m_st[0], m_st[1], m_st[2]};
        m_wi = m_wi + 1;
        m_cnt = 0;
      end else m_cnt++;
    end
    if (be[2]) m_mask = d[23:16];
    @(negedge clk);
    host_wr = 0; host_be = 0;
  endtask

  task automatic hread(input logic [3:0] be, input string tag);
    logic [31:0] e;
    @(negedge clk);
    host_rd = 1; host_be = be;
    e = {m_ri, m_mask, 8'h00, m_wi};      // R7
    if (be[1]) begin                       // R5 / R6 / R10
      if (m_cnt == 0) begin
        m_st[0] = ref_mem[m_ri][23:16];
        m_st[1] = ref_mem[m_ri][15:8];
        m_st[2] = ref_mem[m_ri][7:0];
      end
      e[15:8] = m_st[m_cnt];
      if (m_cnt == 2) begin m_ri = m_ri + 1; m_cnt = 0; end
      else m_cnt++;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 0; host_be = 0;
  endtask

  task automatic triple_wr(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    hwrite(4'b0010, {16'h0, r, 8'h0});
    hwrite(4'b0010, {16'h0, g, 8'h0});
    hwrite(4'b0010, {16'h0, b, 8'h0});
  endtask

  task automatic pix_check(input logic [7:0] idx, input string tag);
    @(negedge clk);
    pix_idx = idx;
    @(negedge clk);
    chk(pix_rgb === ref_mem[idx], tag, {8'h0, pix_rgb}, {8'h0, ref_mem[idx]});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 24'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    hread(4'b1101, "R1 reset lanes");

    // R4 / R5 / R6 basic triple round trip
    hwrite(4'b0001, 32'h0000_0005);
    triple_wr(8'h12, 8'h34, 8'h56);
    hwrite(4'b1000, 32'h0500_0000);
    hread(4'b0010, "R5 red");
    hread(4'b0010, "R5 green");
    hread(4'b0010, "R6 blue");
    hread(4'b1101, "R4 R6 indices advanced");

    // R3: mask applies to writes
    hwrite(4'b0100, 32'h000F_0000);
    hread(4'b0100, "R3 mask readback");
    hwrite(4'b0001, 32'h0000_000A);
    triple_wr(8'hAB, 8'hCD, 8'hEF);
    pix_check(8'd10, "R3 R8 masked entry");
    pix_check(8'd5,  "R8 lookup entry 5");
    hwrite(4'b0100, 32'h00FF_0000);

    // R4 / R6 wrap at 255
    hwrite(4'b1001, 32'hFF00_00FF);
    triple_wr(8'hA1, 8'hB2, 8'hC3);
    hread(4'b0001, "R4 write index wrap");
    hread(4'b0010, "R5 wrap red");
    hread(4'b0010, "R5 wrap green");
    hread(4'b0010, "R6 wrap blue");
    hread(4'b1000, "R6 read index wrap");
    pix_check(8'd255, "R8 lookup entry 255");

    // R2: index write clears the counter
    hwrite(4'b0001, 32'h0000_0014);
    hwrite(4'b0010, 32'h0000_9900);
    hwrite(4'b0001, 32'h0000_0014);
    triple_wr(8'h01, 8'h02, 8'h03);
    pix_check(8'd20, "R2 restart after index write");

    // R2: data lane ignored when an index lane is written
    hwrite(4'b0011, 32'h0000_EE1E);
    triple_wr(8'h44, 8'h55, 8'h66);
    pix_check(8'd30, "R2 combined write ignored data");

    // R7: non-data read keeps the counter
    hwrite(4'b1000, 32'h0500_0000);
    hread(4'b0010, "R7 first component");
    hread(4'b1101, "R7 non-data read");
    hread(4'b0010, "R7 counter kept");
    hread(4'b0010, "R7 last component");

    // R10: shared counter after a partial write triple
    hwrite(4'b0001, 32'h0000_0028);
    hwrite(4'b0010, 32'h0000_7700);
    hread(4'b0010, "R10 shared slot read");
    hread(4'b0010, "R10 shared slot read 2");

    // R9: read with simultaneous write is dropped
    @(negedge clk);
    host_rd = 1; host_wr = 1; host_be = 4'b0100; host_wdata = 32'h00FF_0000;
    @(negedge clk);
    host_rd = 0; host_wr = 0; host_be = 0;
    chk(host_rvalid === 1'b0, "R9 no rvalid", {31'h0, host_rvalid}, 32'h0);
    hread(4'b0100, "R9 write side still applied");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule